// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block collects interrupt requests from peripherals into one 32-bit status register and gates them with a 32-bit enable mask. Both registers are reached through a small register bus that carries either a full 32-bit access or a narrow 16-bit access on the low half. Each peripheral raises its status bit with a one-cycle set pulse. A dedicated pulse input carries the summary event from the DMA engine. Software clears a handled event by writing the status register: every bit written as 0 is cleared and every bit written as 1 is left alone.

Two status positions can be configured as sticky sources. While its configuration input is high, a sticky bit is forced back on whenever the status register is written, before the clearing mask is applied. It is also forced on once just after reset. A single registered CPU interrupt line is high while any status bit is also enabled in the mask. Rewriting the mask so that it exposes an event that is already waiting produces a one-cycle recheck pulse. The CPU can use that pulse to re-examine its interrupt state at once.

A small sequencer has two states. SEED is entered by reset and lasts for exactly one clock. In it, the enabled sticky bits are loaded, and the transition SEED to RUN is always taken. RUN is the working state, and its only transition is RUN to RUN.

Top module: `irq_status_ctrl`

## Requirements
- R1: While reset is asserted, status and mask read as zero and irq_out and recheck_pulse are low.
- R2: On the first clock after reset is released (state SEED), status bit 7 becomes cfg_sticky_a and status bit 9 becomes cfg_sticky_b. The block then moves to RUN and does not seed again.
- R3: A write to byte offset 0x70 ANDs the status with the written value, so bits written 0 are cleared and bits written 1 keep their value.
- R4: On a status write, each enabled sticky bit (7 for cfg_sticky_a, 9 for cfg_sticky_b) is ORed into the status before the AND. Writing 1 to such a bit therefore leaves it set even if it was clear.
- R5: A high src_set[i] sets status bit i on the next clock. A high dma_irq sets status bit 3 on the next clock.
- R6: When a set input and a status-write clear hit the same bit in the same cycle, the bit ends up set.
- R7: A write to byte offset 0x74 replaces the mask. Reading 0x74 returns the mask.
- R8: With bus_wide low, a write changes only bits 15:0 of the target register, and a read returns bits 31:16 as zero. With bus_wide high, all 32 bits are written or read.
- R9: irq_out is a registered signal. It equals the OR of (status AND mask) one clock after those registers take their values.
- R10: recheck_pulse is high for exactly the one cycle after a mask write, and only when the previous status AND the new mask is non-zero.
- R11: Writes to offsets other than 0x70 and 0x74 change no register, and reads of them return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_sticky_a | input | 1 | Enables the sticky source at status bit 7 |
| cfg_sticky_b | input | 1 | Enables the sticky source at status bit 9 |
| bus_wr | input | 1 | Write strobe for the current bus cycle |
| bus_wide | input | 1 | 1 for a 32-bit access, 0 for a 16-bit access on bits 15:0 |
| bus_addr | input | 8 | Byte offset inside the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| src_set | input | 32 | Per-bit status set pulses from peripherals |
| dma_irq | input | 1 | DMA summary event pulse, sets status bit 3 |
| irq_out | output | 1 | Registered interrupt request to the CPU |
| recheck_pulse | output | 1 | One-cycle pulse when a mask write exposes a pending event |

## Verification
The embedded properties look back one clock with $past. They therefore assume that bus_wr, src_set and dma_irq are held low while reset is asserted, so the cycle seen just after release reflects no bus or source activity. They also assume that the sticky configuration inputs change only while the block is in reset. The stimulus is applied on falling clock edges only. It holds every bus and source input at zero around reset, and it changes the configuration only before releasing reset, sweeping all four combinations.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

    typedef enum logic [0:0] {
        ST_SEED = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    localparam int unsigned REG_W   = 32;
    localparam int unsigned NARROW_W = 16;

endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned HALF_W   = 16,
    parameter int unsigned STAT_OFS = 'h70,
    parameter int unsigned MASK_OFS = 'h74
) (
    input  logic              bus_wr,
    input  logic              bus_wide,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] status,
    input  logic [DATA_W-1:0] mask,
    output logic              stat_wr,
    output logic              mask_wr,
    output logic [DATA_W-1:0] keep_mask,
    output logic [DATA_W-1:0] wval,
    output logic [DATA_W-1:0] ack_val,
    output logic [DATA_W-1:0] rdata
);

    localparam logic [DATA_W-1:0] UPPER_ONES =
        {{(DATA_W-HALF_W){1'b1}}, {HALF_W{1'b0}}};
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
    localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(MASK_OFS);

    logic hit_stat;
    logic hit_mask;
    logic [DATA_W-1:0] sel;

    always_comb begin
        hit_stat  = (bus_addr == STAT_A);
        hit_mask  = (bus_addr == MASK_A);
        stat_wr   = bus_wr && hit_stat;
        mask_wr   = bus_wr && hit_mask;
        keep_mask = bus_wide ? '0 : UPPER_ONES;
        wval      = bus_wdata & ~keep_mask;
        ack_val   = wval | keep_mask;
        if (hit_stat)      sel = status;
        else if (hit_mask) sel = mask;
        else               sel = '0;
        rdata = sel & ~keep_mask;
    end

endmodule

// File: rtl/irq_status_core.sv
module irq_status_core
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned STICKY_A = 7,
    parameter int unsigned STICKY_B = 9,
    parameter int unsigned DMA_BIT  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_a,
    input  logic              cfg_b,
    input  logic              stat_wr,
    input  logic [DATA_W-1:0] ack_val,
    input  logic [DATA_W-1:0] src_set,
    input  logic              dma_pulse,
    output logic [DATA_W-1:0] status
);

    seq_state_e        state_q, state_d;
    logic [DATA_W-1:0] status_q, status_d;
    logic [DATA_W-1:0] sticky_vec;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] base;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_SEED;
            status_q <= '0;
        end else begin
            state_q  <= state_d;
            status_q <= status_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEED: state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        sticky_vec           = '0;
        sticky_vec[STICKY_A] = cfg_a;
        sticky_vec[STICKY_B] = cfg_b;
        set_vec              = src_set;
        set_vec[DMA_BIT]     = src_set[DMA_BIT] | dma_pulse;
        base = status_q;
        if (state_q == ST_SEED) base = base | sticky_vec;
        if (stat_wr)            base = (base | sticky_vec) & ack_val;
        status_d = base | set_vec;
    end

    assign status = status_q;

    assert_seed_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEED && !stat_wr && cfg_a) |=> status_q[STICKY_A]);

    assert_seed_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEED && !stat_wr && cfg_b) |=> status_q[STICKY_B]);

    assert_ack_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> ((status_q & ~($past(ack_val) | $past(set_vec))) == '0));

    assert_sticky_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && cfg_a && ack_val[STICKY_A]) |=> status_q[STICKY_A]);

    assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

endmodule

// File: rtl/irq_mask_out.sv
module irq_mask_out #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] status,
    input  logic              mask_wr,
    input  logic [DATA_W-1:0] keep_mask,
    input  logic [DATA_W-1:0] wval,
    output logic [DATA_W-1:0] mask,
    output logic              irq_out,
    output logic              recheck_pulse
);

    logic [DATA_W-1:0] mask_q, mask_d;
    logic              irq_q, irq_d;
    logic              rc_q, rc_d;

    always_comb begin
        mask_d = mask_wr ? ((mask_q & keep_mask) | wval) : mask_q;
        rc_d   = mask_wr && ((status & mask_d) != '0);
        irq_d  = |(status & mask_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            irq_q  <= 1'b0;
            rc_q   <= 1'b0;
        end else begin
            mask_q <= mask_d;
            irq_q  <= irq_d;
            rc_q   <= rc_d;
        end
    end

    assign mask          = mask_q;
    assign irq_out       = irq_q;
    assign recheck_pulse = rc_q;

    assert_recheck_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        recheck_pulse |-> $past(mask_wr));

    assert_mask_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && keep_mask != '0) |=>
            (mask_q[DATA_W-1:HALF_W] == $past(mask_q[DATA_W-1:HALF_W])));

    assert_irq_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past((status & mask_q) != '0));

endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned STAT_OFS = 'h70,
    parameter int unsigned MASK_OFS = 'h74,
    parameter int unsigned STICKY_A = 7,
    parameter int unsigned STICKY_B = 9,
    parameter int unsigned DMA_BIT  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_sticky_a,
    input  logic              cfg_sticky_b,
    input  logic              bus_wr,
    input  logic              bus_wide,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       src_set,
    input  logic              dma_irq,
    output logic              irq_out,
    output logic              recheck_pulse
);

    localparam int unsigned DW = REG_W;
    localparam int unsigned HW = NARROW_W;

    logic          stat_wr;
    logic          mask_wr;
    logic [DW-1:0] keep_mask;
    logic [DW-1:0] wval;
    logic [DW-1:0] ack_val;
    logic [DW-1:0] status;
    logic [DW-1:0] mask;

    irq_reg_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DW), .HALF_W(HW),
        .STAT_OFS(STAT_OFS), .MASK_OFS(MASK_OFS)
    ) u_decode (
        .bus_wr(bus_wr), .bus_wide(bus_wide), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .status(status), .mask(mask),
        .stat_wr(stat_wr), .mask_wr(mask_wr), .keep_mask(keep_mask),
        .wval(wval), .ack_val(ack_val), .rdata(bus_rdata)
    );

    irq_status_core #(
        .DATA_W(DW), .STICKY_A(STICKY_A), .STICKY_B(STICKY_B), .DMA_BIT(DMA_BIT)
    ) u_status (
        .clk(clk), .rst_n(rst_n), .cfg_a(cfg_sticky_a), .cfg_b(cfg_sticky_b),
        .stat_wr(stat_wr), .ack_val(ack_val), .src_set(src_set),
        .dma_pulse(dma_irq), .status(status)
    );

    irq_mask_out #(
        .DATA_W(DW), .HALF_W(HW)
    ) u_mask (
        .clk(clk), .rst_n(rst_n), .status(status), .mask_wr(mask_wr),
        .keep_mask(keep_mask), .wval(wval), .mask(mask),
        .irq_out(irq_out), .recheck_pulse(recheck_pulse)
    );

endmodule

// File: tb/irq_status_ctrl_tb.sv
module irq_status_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_sticky_a = 1'b0;
    logic        cfg_sticky_b = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_wide = 1'b1;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src_set = '0;
    logic        dma_irq = 1'b0;
    logic        irq_out;
    logic        recheck_pulse;

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_stat;
    logic [31:0] exp_mask;
    logic [31:0] sticky;
    logic        exp_rc;

    always #5 clk = ~clk;

    irq_status_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_sticky_a(cfg_sticky_a),
        .cfg_sticky_b(cfg_sticky_b), .bus_wr(bus_wr), .bus_wide(bus_wide),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_set(src_set), .dma_irq(dma_irq), .irq_out(irq_out),
        .recheck_pulse(recheck_pulse)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic wide, output logic [31:0] d);
        bus_addr = a;
        bus_wide = wide;
        #1;
        d = bus_rdata;
        bus_wide = 1'b1;
    endtask

    task automatic drive(input logic wr, input logic wide, input logic [7:0] a,
                         input logic [31:0] wd, input logic [31:0] setv, input logic dma);
        logic [31:0] fullset;
        logic [31:0] ack;
        logic [31:0] nmask;
        @(negedge clk);
        bus_wr = wr; bus_wide = wide; bus_addr = a; bus_wdata = wd;
        src_set = setv; dma_irq = dma;
        fullset = setv | (32'(dma) << 3);
        ack     = wide ? wd : {16'hFFFF, wd[15:0]};
        nmask   = wide ? wd : {exp_mask[31:16], wd[15:0]};
        exp_rc  = 1'b0;
        if (wr && a == 8'h74) begin
            exp_rc   = (exp_stat & nmask) != 0;
            exp_mask = nmask;
        end
        if (wr && a == 8'h70) exp_stat = ((exp_stat | sticky) & ack) | fullset;
        else                  exp_stat = exp_stat | fullset;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; src_set = '0; dma_irq = 1'b0; bus_wide = 1'b1;
        chk("R10 recheck_pulse", 32'(recheck_pulse), 32'(exp_rc));
    endtask

    task automatic check_regs(input string tag);
        logic [31:0] d;
        rd(8'h70, 1'b1, d); chk({tag, " status"}, d, exp_stat);
        rd(8'h74, 1'b1, d); chk({tag, " mask"}, d, exp_mask);
    endtask

    task automatic check_irq();
        @(negedge clk);
        chk("R9 irq_out", 32'(irq_out), 32'(|(exp_stat & exp_mask)));
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int cfg = 0; cfg < 4; cfg++) begin
            rst_n = 1'b0;
            cfg_sticky_a = cfg[0];
            cfg_sticky_b = cfg[1];
            sticky = (32'(cfg[0]) << 7) | (32'(cfg[1]) << 9);
            repeat (2) @(negedge clk);
            rd(8'h70, 1'b1, d); chk("R1 status in reset", d, 32'h0);
            rd(8'h74, 1'b1, d); chk("R1 mask in reset", d, 32'h0);
            chk("R1 irq in reset", 32'(irq_out), 32'h0);
            chk("R1 recheck in reset", 32'(recheck_pulse), 32'h0);
            rst_n = 1'b1;
            @(negedge clk);
            exp_stat = sticky;
            exp_mask = '0;
            rd(8'h70, 1'b1, d); chk("R2 seeded status", d, sticky);
            // R2: a cleared sticky bit is not seeded again in RUN
            drive(1'b1, 1'b1, 8'h70, 32'h0, 32'h0, 1'b0);
            repeat (2) @(negedge clk);
            rd(8'h70, 1'b1, d); chk("R2 no reseed", d, 32'h0);

            for (int p = 0; p < 16; p++) begin
                logic [31:0] s;
                s = (32'(p & 1)) | (32'((p >> 1) & 1) << 5) |
                    (32'((p >> 2) & 1) << 12) | (32'((p >> 3) & 1) << 20);
                drive(1'b0, 1'b1, 8'h00, 32'h0, s, 1'b0);
                check_regs("R5 set");
                drive(1'b1, 1'b1, 8'h74, (p % 2 == 1) ? s : ~s, 32'h0, 1'b0);
                check_regs("R7 mask write");
                check_irq();
                drive(1'b1, 1'b0, 8'h74, 32'hA5A5_FFFF, 32'h0, 1'b0);
                check_regs("R8 narrow mask write");
                rd(8'h74, 1'b0, d); chk("R8 narrow read", d, {16'h0, exp_mask[15:0]});
                check_irq();
                // R3 and R6: clear everything set, while bit 20 may be set again
                drive(1'b1, 1'b1, 8'h70, ~s, s & 32'h0010_0000, 1'b0);
                check_regs("R6 set beats ack / R3 ack");
                drive(1'b0, 1'b1, 8'h00, 32'h0, 32'h0, 1'b1);
                check_regs("R5 dma bit3");
                drive(1'b1, 1'b0, 8'h70, 32'h0, 32'h0, 1'b0);
                check_regs("R8 narrow ack");
                drive(1'b1, 1'b1, 8'h70, 32'h0000_0280, 32'h0, 1'b0);
                check_regs("R4 sticky reassert");
                drive(1'b1, 1'b1, 8'h78, 32'hFFFF_FFFF, 32'h0, 1'b0);
                check_regs("R11 other offset write");
                rd(8'h78, 1'b1, d); chk("R11 other offset read", d, 32'h0);
                check_irq();
                drive(1'b1, 1'b1, 8'h70, 32'h0, 32'h0, 1'b0);
                drive(1'b1, 1'b1, 8'h74, 32'h0, 32'h0, 1'b0);
            end
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule